// File: doc/BRIEF.md
# Single-Precision Floating-Point Comparator

This block compares two IEEE-754 single-precision operands. A request gives the two operands, a 3-bit compare code and a valid strobe. On the clock edge that accepts the request, the block classifies both operands and orders them. It reduces the compare code to one condition bit and registers the result with a set of status bits. In the cycle after acceptance, a write strobe tells the surrounding pipeline to take the condition flag into its flag register. The status bits report:

- whether the operands were unordered,
- whether the compare was invalid,
- whether either operand was an infinity,
- whether either operand was a zero.

Control is a two-state machine. `ST_IDLE` means no result is being presented. `ST_REPORT` means the registered result of the request accepted on the previous edge is on the outputs with the strobe high. The transitions are:

- **accept** (`ST_IDLE` to `ST_REPORT`): taken when `req_valid` is high.
- **chain** (`ST_REPORT` to `ST_REPORT`): a new request arrives while a result is being presented.
- **drain** (`ST_REPORT` to `ST_IDLE`): no request arrives.

Between requests the flag and the status bits keep their last values.

Top module: `fcmp_unit`

## Requirements
- R1: An operand whose exponent bits [30:23] are all ones, with bit 22 clear and bits [21:0] not all zero, is a signaling NaN. It makes `invalid` high for every compare code, including EQ.
- R2: An operand whose exponent bits are all ones and bit 22 is set is a quiet NaN. It makes `unordered` high, and `invalid` high for every code except EQ.
- R3: `inf_seen` is high when either operand has all-ones exponent bits and fraction bits [22:0] all zero.
- R4: `zero_seen` is high when bits [30:0] of either operand are all zero. Bit 31 is ignored, so +0 and -0 compare equal.
- R5: For code EQ, `invalid` is set only by a signaling NaN operand. For every other code, `invalid` is set by any NaN operand.
- R6: Compare codes are EQ=0, NE=1, GT=2, GE=3, LT=4 and LE=5. The flag is:
  - EQ: a==b.
  - NE: not (a==b).
  - GT: b<a and not equal.
  - GE: b<a or equal.
  - LT: a<b and not equal.
  - LE: a<b or equal.
- R7: `flag_we` is high for exactly the one cycle after each edge that samples `req_valid` high. Results appear in that cycle. Requests on consecutive cycles give consecutive strobes.
- R8: When either operand is a NaN, `unordered` is high and no ordering or equality relation holds. The flag is therefore 1 for NE and 0 for every other code.
- R9: Non-NaN operands are ordered by sign and magnitude. A negative value is below a positive one, and of two negatives the one with the larger magnitude is the smaller.
- R10: Codes 6 and 7 give a flag of 0 and still produce the write strobe.
- R11: While `rst_n` is low, every output is 0.
- R12: In a cycle whose preceding edge saw no request, the flag and the status outputs hold their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Compare request strobe |
| req_code | input | 3 | Compare code (R6, R10) |
| op_a | input | 32 | First operand, single precision |
| op_b | input | 32 | Second operand, single precision |
| flag | output | 1 | Condition result |
| flag_we | output | 1 | Write strobe for the condition result |
| unordered | output | 1 | At least one operand was a NaN |
| invalid | output | 1 | Invalid-operation status |
| inf_seen | output | 1 | At least one operand was an infinity |
| zero_seen | output | 1 | At least one operand was a zero |

## Verification
The assertions assume that `req_code`, `op_a` and `op_b` are known and stable around every clock edge that samples `req_valid` high. They also assume that `req_valid` itself is never unknown once reset is released. The bench keeps to this by changing every input only on the falling clock edge and by driving defined values from time zero. It also drives junk operands during idle cycles, so that the hold behaviour is checked against inputs that really move.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;

    typedef enum logic [2:0] {
        CC_EQ   = 3'd0,
        CC_NE   = 3'd1,
        CC_GT   = 3'd2,
        CC_GE   = 3'd3,
        CC_LT   = 3'd4,
        CC_LE   = 3'd5,
        CC_RSV6 = 3'd6,
        CC_RSV7 = 3'd7
    } cmp_code_e;

    typedef enum logic {
        ST_IDLE,
        ST_REPORT
    } fsm_e;

    // Per-operand classification
    typedef struct packed {
        logic sign;
        logic nan;
        logic snan;
        logic inf;
        logic zero;
    } op_class_t;

    // Relation between the two operands; exactly one bit is set
    typedef struct packed {
        logic unord;
        logic lt;
        logic gt;
        logic eq;
    } rel_t;

endpackage

// File: rtl/fcmp_classify.sv
module fcmp_classify
    import fcmp_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int W     = 1 + EXP_W + FRAC_W
) (
    input  logic [W-1:0] op,
    output op_class_t    cls,
    output logic [W-2:0] mag
);
    logic [EXP_W-1:0]  exp_f;
    logic [FRAC_W-1:0] frac_f;
    logic              exp_ones;
    logic              frac_nz;

    always_comb begin
        exp_f    = op[W-2 -: EXP_W];
        frac_f   = op[FRAC_W-1:0];
        exp_ones = &exp_f;
        frac_nz  = |frac_f;
        mag      = op[W-2:0];

        cls.sign = op[W-1];
        cls.nan  = exp_ones & frac_nz;
        // Top fraction bit clear marks the signaling kind
        cls.snan = exp_ones & ~frac_f[FRAC_W-1] & (|frac_f[FRAC_W-2:0]);
        cls.inf  = exp_ones & ~frac_nz;
        cls.zero = ~(|op[W-2:0]);
    end
endmodule

// File: rtl/fcmp_order.sv
module fcmp_order
    import fcmp_pkg::*;
#(
    parameter int MAG_W = 31
) (
    input  op_class_t        cls_a,
    input  op_class_t        cls_b,
    input  logic [MAG_W-1:0] mag_a,
    input  logic [MAG_W-1:0] mag_b,
    output rel_t             rel
);
    logic unord;
    logic both_zero;
    logic same_sign;
    logic mag_lt;
    logic mag_gt;
    logic mag_eq;

    always_comb begin
        unord     = cls_a.nan | cls_b.nan;
        both_zero = cls_a.zero & cls_b.zero;
        same_sign = cls_a.sign == cls_b.sign;
        mag_lt    = mag_a < mag_b;
        mag_gt    = mag_a > mag_b;
        mag_eq    = mag_a == mag_b;

        rel.unord = unord;
        rel.eq    = ~unord & (both_zero | (same_sign & mag_eq));
        if (unord || both_zero) begin
            rel.lt = 1'b0;
            rel.gt = 1'b0;
        end else if (!same_sign) begin
            rel.lt = cls_a.sign;
            rel.gt = cls_b.sign;
        end else if (cls_a.sign) begin
            rel.lt = mag_gt;
            rel.gt = mag_lt;
        end else begin
            rel.lt = mag_lt;
            rel.gt = mag_gt;
        end
    end
endmodule

// File: rtl/fcmp_decide.sv
module fcmp_decide
    import fcmp_pkg::*;
(
    input  logic [2:0] code,
    input  rel_t       rel,
    input  logic       any_snan,
    output logic       flag,
    output logic       invalid
);
    cmp_code_e cc;

    always_comb begin
        cc = cmp_code_e'(code);
        unique case (cc)
            CC_EQ:   flag = rel.eq;
            CC_NE:   flag = ~rel.eq;
            CC_GT:   flag = rel.gt & ~rel.eq;
            CC_GE:   flag = rel.gt | rel.eq;
            CC_LT:   flag = rel.lt & ~rel.eq;
            CC_LE:   flag = rel.lt | rel.eq;
            CC_RSV6,
            CC_RSV7: flag = 1'b0;
        endcase
        invalid = (cc == CC_EQ) ? any_snan : rel.unord;
    end
endmodule

// File: rtl/fcmp_unit.sv
module fcmp_unit
    import fcmp_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int W     = 1 + EXP_W + FRAC_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         req_valid,
    input  logic [2:0]   req_code,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    output logic         flag,
    output logic         flag_we,
    output logic         unordered,
    output logic         invalid,
    output logic         inf_seen,
    output logic         zero_seen
);
    localparam int N_OPS = 2;

    logic [W-1:0]   ops     [N_OPS];
    op_class_t      cls     [N_OPS];
    logic [W-2:0]   mags    [N_OPS];
    rel_t           rel;
    logic           flag_d;
    logic           invalid_d;
    fsm_e           state_q;
    fsm_e           state_d;

    assign ops[0] = op_a;
    assign ops[1] = op_b;

    for (genvar g = 0; g < N_OPS; g++) begin : g_cls
        fcmp_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
            .op  (ops[g]),
            .cls (cls[g]),
            .mag (mags[g])
        );
    end

    fcmp_order #(.MAG_W(W-1)) u_order (
        .cls_a (cls[0]),
        .cls_b (cls[1]),
        .mag_a (mags[0]),
        .mag_b (mags[1]),
        .rel   (rel)
    );

    fcmp_decide u_decide (
        .code     (req_code),
        .rel      (rel),
        .any_snan (cls[0].snan | cls[1].snan),
        .flag     (flag_d),
        .invalid  (invalid_d)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state: accept, chain, drain
    always_comb begin
        unique case (state_q)
            ST_IDLE:   state_d = req_valid ? ST_REPORT : ST_IDLE;
            ST_REPORT: state_d = req_valid ? ST_REPORT : ST_IDLE;
        endcase
    end

    // Output process: result registers load on an accepted request
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag      <= 1'b0;
            unordered <= 1'b0;
            invalid   <= 1'b0;
            inf_seen  <= 1'b0;
            zero_seen <= 1'b0;
        end else if (req_valid) begin
            flag      <= flag_d;
            unordered <= rel.unord;
            invalid   <= invalid_d;
            inf_seen  <= cls[0].inf | cls[1].inf;
            zero_seen <= cls[0].zero | cls[1].zero;
        end
    end

    assign flag_we = (state_q == ST_REPORT);

    // ---------------- assertions ----------------
    p_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> flag_we);

    p_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !flag_we);

    p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> $stable({flag, unordered, invalid, inf_seen, zero_seen}));

    p_nan_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && rel.unord) |=> (flag == ($past(req_code) == CC_NE)));

    p_nan_invalid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && rel.unord && req_code != CC_EQ) |=> invalid);

    p_rsv_code_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_code[2:1] == 2'b11) |=> (flag_we && !flag));

    p_one_relation_r9: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> ($countones({rel.unord, rel.lt, rel.gt, rel.eq}) == 1));

    p_signed_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && cls[0].zero && cls[1].zero) |-> rel.eq);
endmodule

// File: tb/fcmp_unit_tb_top.sv
`timescale 1ns/1ps
module fcmp_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_code = 3'd0;
    logic [31:0] op_a = 32'h0;
    logic [31:0] op_b = 32'h0;
    logic        flag, flag_we, unordered, invalid, inf_seen, zero_seen;

    always #10 clk = ~clk;

    fcmp_unit dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_code(req_code),
        .op_a(op_a), .op_b(op_b), .flag(flag), .flag_we(flag_we),
        .unordered(unordered), .invalid(invalid), .inf_seen(inf_seen),
        .zero_seen(zero_seen)
    );

    typedef struct packed {
        logic [31:0] due;
        logic        flag;
        logic        unord;
        logic        inv;
        logic        inf;
        logic        zero;
    } exp_t;

    exp_t        q[$];
    string       tq[$];
    int          n_chk = 0;
    int          n_bad = 0;
    int          cyc = 0;
    logic        mon_on = 1'b0;
    logic        done = 1'b0;
    logic [3:0]  last = 4'h0;   // flag, unord, inv, inf, zero kept below
    logic        last_zero = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input logic ok, input string req, input logic [31:0] act,
                         input logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, expv, cyc);
        end
    endtask

    function automatic logic is_nan(input logic [31:0] v);
        return (v[30:23] == 8'hFF) && (v[22:0] != 0);
    endfunction
    function automatic logic is_snan(input logic [31:0] v);
        return (v[30:23] == 8'hFF) && !v[22] && (v[21:0] != 0);
    endfunction
    function automatic logic is_inf(input logic [31:0] v);
        return (v[30:23] == 8'hFF) && (v[22:0] == 0);
    endfunction
    function automatic logic is_zero(input logic [31:0] v);
        return v[30:0] == 0;
    endfunction
    function automatic longint key(input logic [31:0] v);
        longint m = longint'(v[30:0]);
        return v[31] ? -m : m;
    endfunction

    // Driver: present one request and push its expected result
    task automatic send(input logic [31:0] a, input logic [31:0] b, input int code);
        exp_t  e;
        string tag;
        logic  un, lt, gt, eq, sn;
        @(negedge clk);
        op_a = a; op_b = b; req_code = code[2:0]; req_valid = 1'b1;
        un = is_nan(a) || is_nan(b);
        sn = is_snan(a) || is_snan(b);
        eq = !un && (key(a) == key(b));
        lt = !un && (key(a) <  key(b));
        gt = !un && (key(a) >  key(b));
        case (code)
            0: e.flag = eq;
            1: e.flag = !eq;
            2: e.flag = gt;
            3: e.flag = gt || eq;
            4: e.flag = lt;
            5: e.flag = lt || eq;
            default: e.flag = 1'b0;
        endcase
        e.unord = un;
        e.inv   = (code == 0) ? sn : un;
        e.inf   = is_inf(a) || is_inf(b);
        e.zero  = is_zero(a) || is_zero(b);
        e.due   = 32'(cyc + 1);
        if (code > 5)                        tag = "R10";
        else if (sn)                         tag = "R1";
        else if (un)                         tag = "R2 R8";
        else if (is_zero(a) && is_zero(b))   tag = "R4";
        else if (a[31] || b[31])             tag = "R9";
        else                                 tag = "R6";
        q.push_back(e);
        tq.push_back(tag);
    endtask

    task automatic idle(input logic [31:0] junk);
        @(negedge clk);
        req_valid = 1'b0;
        op_a = junk; op_b = ~junk; req_code = junk[2:0];
    endtask

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (mon_on) begin
            if (q.size() > 0 && q[0].due == 32'(cyc)) begin
                exp_t  e;
                string t;
                e = q.pop_front();
                t = tq.pop_front();
                check(flag_we == 1'b1, "R7 strobe", 32'(flag_we), 1);
                check(flag == e.flag, {t, " R6 flag"}, 32'(flag), 32'(e.flag));
                check(unordered == e.unord, "R8 unordered", 32'(unordered), 32'(e.unord));
                check(invalid == e.inv, "R5 invalid", 32'(invalid), 32'(e.inv));
                check(inf_seen == e.inf, "R3 inf_seen", 32'(inf_seen), 32'(e.inf));
                check(zero_seen == e.zero, "R4 zero_seen", 32'(zero_seen), 32'(e.zero));
                last = {e.flag, e.unord, e.inv, e.inf};
                last_zero = e.zero;
            end else begin
                check(flag_we == 1'b0, "R7 no strobe when idle", 32'(flag_we), 0);
                check({flag, unordered, invalid, inf_seen, zero_seen} == {last, last_zero},
                      "R12 hold", 32'({flag, unordered, invalid, inf_seen, zero_seen}),
                      32'({last, last_zero}));
            end
        end
    end

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

    localparam int NP = 14;
    logic [31:0] pa [NP];
    logic [31:0] pb [NP];

    initial begin
        pa[0]  = 32'h3F800000; pb[0]  = 32'h40000000; // 1, 2
        pa[1]  = 32'h40000000; pb[1]  = 32'h3F800000; // 2, 1
        pa[2]  = 32'hBF800000; pb[2]  = 32'hC0000000; // -1, -2
        pa[3]  = 32'hC0000000; pb[3]  = 32'hBF800000; // -2, -1
        pa[4]  = 32'h00000000; pb[4]  = 32'h80000000; // +0, -0
        pa[5]  = 32'hBF800000; pb[5]  = 32'h3F800000; // -1, +1
        pa[6]  = 32'h7F800000; pb[6]  = 32'h7F7FFFFF; // +inf, max finite
        pa[7]  = 32'hFF800000; pb[7]  = 32'hFF800000; // -inf, -inf
        pa[8]  = 32'h7FC00000; pb[8]  = 32'h3F800000; // qNaN, 1
        pa[9]  = 32'h3F800000; pb[9]  = 32'h7F800001; // 1, sNaN
        pa[10] = 32'h7FA00000; pb[10] = 32'h7FA00000; // sNaN, sNaN
        pa[11] = 32'h00000000; pb[11] = 32'h00000001; // +0, +denorm
        pa[12] = 32'h80000000; pb[12] = 32'h80000001; // -0, -denorm
        pa[13] = 32'h40490FDB; pb[13] = 32'h40490FDB; // equal values

        repeat (3) @(negedge clk);
        // R11: outputs are zero while reset is held
        check(flag_we == 1'b0, "R11 flag_we in reset", 32'(flag_we), 0);
        check({flag, unordered, invalid, inf_seen, zero_seen} == 5'b0,
              "R11 status in reset", 32'({flag, unordered, invalid, inf_seen, zero_seen}), 0);
        rst_n = 1'b1;
        mon_on = 1'b1;
        idle(32'h12345678);

        for (int p = 0; p < NP; p++) begin
            for (int c = 0; c < 8; c++) begin
                send(pa[p], pb[p], c);
                if (((p + c) % 3) == 0) idle(32'hA5A50000 ^ 32'(p * 8 + c));
            end
        end
        repeat (4) idle(32'hDEADBEEF);
        check(q.size() == 0, "R7 all strobes seen", 32'(q.size()), 0);
        done = 1'b1;
        summary();
    end
endmodule